// File: doc/BRIEF.md
# Cascadable Microprogram Sequencer Slice

This block is one narrow slice of a next-microinstruction address generator. Each slice covers a few address bits. Slices are chained through their carry pins to form a wider control store address. Inside a slice sit four parts: an address register, a microprogram counter fed by an incrementer, a small push/pop return stack, and a four-way source multiplexer. The multiplexer output is the next address.

Every control input comes straight from bits of an external pipeline register. These bits are the two source-select lines, the address register load, the stack enable and the stack direction. A forcing input drives the next address to zero after the multiplexer. The forced value is also the value the incrementer sees. The address output can be released to high impedance so that other drivers can share the address bus. Condition testing and instruction decoding are done outside the slice.

Top module: `useq_slice`

## Requirements
- R1: While `rst_n` is low, the address register, the microprogram counter, the stack pointer and every stack word are cleared to zero. After reset, each of the sources 0, 2 and 3 therefore presents 0.
- R2: `src_sel` picks the next address combinationally: 0 selects the address register, 1 selects `din`, 2 selects the microprogram counter, and 3 selects the top stack word.
- R3: On a rising edge with `areg_ld` high, the address register takes `din`. With `areg_ld` low it keeps its value.
- R4: On every rising edge, the microprogram counter loads the next address plus `cin`, modulo 2^W. With `cin` at 0 it therefore repeats the same address. `cout` is high exactly when `cin` is high and every next-address bit is 1.
- R5: While `zero_nxt` is high, every next-address bit is 0, whatever `src_sel` selects. The counter then loads `cin`.
- R6: On an edge with `stk_en` high and `stk_push` high, the current counter value is written one location above the top, and the pointer advances. From the next cycle, source 3 shows that value.
- R7: On an edge with `stk_en` high and `stk_push` low, the pointer moves back by one (pop). With `stk_en` low, the pointer and all stack words stay unchanged.
- R8: The stack holds DEPTH words (default 4). The pointer wraps modulo DEPTH with no overflow indication, so a fifth push overwrites the oldest entry.
- R9: With `oe` low, every bit of `y` is high impedance. With `oe` high, `y` carries the next address.
- R10: Three slices form a 12-bit sequencer when each `cout` is tied to the next slice's `cin`. The 12-bit counter then steps across slice boundaries, including the wrap from 0xFFF to 0x000. Jump, call, return and continue sequences behave as a single 12-bit sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | W | Direct address bits for this slice |
| src_sel | input | 2 | Next-address source select |
| areg_ld | input | 1 | Load the address register from `din` |
| stk_en | input | 1 | Enable a stack operation this edge |
| stk_push | input | 1 | 1 = push, 0 = pop (when `stk_en` is high) |
| zero_nxt | input | 1 | Force the next address to zero |
| cin | input | 1 | Incrementer carry in |
| oe | input | 1 | Drive `y` when high, release it when low |
| y | output | W | Next address, three-state |
| cout | output | 1 | Incrementer carry out toward the next slice |

## Verification
A call combines two actions in the same cycle: a jump through `din`, and a push of the counter value, which still holds the return point. A return also combines two actions in one cycle: the stack top is selected as the next address while the pointer is popped. The bench provokes both combinations in nested call/return runs. These include a fifth push that overwrites the oldest entry. It also provokes them in a long pseudo-random stream in which every control is toggled freely. In each cycle a 12-bit arithmetic model predicts `y`. The bench checks that a return lands on the address right after its call, and that the stack top seen after a push equals the counter value from before the jump.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [1:0] {
      SRC_AREG   = 2'd0,
      SRC_DIRECT = 2'd1,
      SRC_UPC    = 2'd2,
      SRC_STACK  = 2'd3
   } nxt_src_e;

endpackage

// File: rtl/useq_areg.sv
module useq_areg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (q == $past(d)));
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(q));

endmodule

// File: rtl/useq_upc.sv
module useq_upc #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] nxt,
   input  logic         cin,
   output logic [W-1:0] pc,
   output logic         cout
);

   logic [W:0] sum;

   always_comb begin
      sum  = {1'b0, nxt} + {{W{1'b0}}, cin};
      cout = sum[W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= '0;
      else        pc <= sum[W-1:0];
   end

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cin |=> (pc == $past(nxt)));
   assert_carry_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cout |=> (pc == '0));

endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
   parameter int W     = 4,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         push,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] top
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || DEPTH != (1 << PW)) begin : g_bad_depth
         $error("useq_stack: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] sp;
   logic [PW-1:0] sp_up;
   logic [PW-1:0] sp_dn;

   assign sp_up = sp + PW'(1);
   assign sp_dn = sp - PW'(1);
   assign top   = mem[sp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp <= '0;
      end else if (en) begin
         sp <= push ? sp_up : sp_dn;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (en && push) begin
         mem[sp_up] <= wdata;
      end
   end

   assert_push_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && push) |=> (top == $past(wdata)));
   assert_pop_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !push) |=> (sp == $past(sp_dn)));
   assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(sp) && $stable(top)));
   assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && push && sp == PW'(DEPTH - 1)) |=> (sp == '0));

endmodule

// File: rtl/useq_slice.sv
module useq_slice
   import useq_pkg::*;
#(
   parameter int W     = 4,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   input  logic [1:0]   src_sel,
   input  logic         areg_ld,
   input  logic         stk_en,
   input  logic         stk_push,
   input  logic         zero_nxt,
   input  logic         cin,
   input  logic         oe,
   output logic [W-1:0] y,
   output logic         cout
);

   generate
      if (W < 1) begin : g_bad_width
         $error("useq_slice: W must be at least 1");
      end
   endgenerate

   nxt_src_e     src;
   logic [W-1:0] areg_q;
   logic [W-1:0] pc_q;
   logic [W-1:0] stk_top;
   logic [W-1:0] mux_out;
   logic [W-1:0] nxt;

   assign src = nxt_src_e'(src_sel);

   always_comb begin
      unique case (src)
         SRC_AREG:   mux_out = areg_q;
         SRC_DIRECT: mux_out = din;
         SRC_UPC:    mux_out = pc_q;
         SRC_STACK:  mux_out = stk_top;
         default:    mux_out = '0;
      endcase
      nxt = zero_nxt ? '0 : mux_out;
   end

   assign y = oe ? nxt : {W{1'bz}};

   useq_areg #(.W(W)) u_areg (
      .clk(clk), .rst_n(rst_n), .ld(areg_ld), .d(din), .q(areg_q)
   );

   useq_upc #(.W(W)) u_upc (
      .clk(clk), .rst_n(rst_n), .nxt(nxt), .cin(cin), .pc(pc_q), .cout(cout)
   );

   useq_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
      .clk(clk), .rst_n(rst_n), .en(stk_en), .push(stk_push),
      .wdata(pc_q), .top(stk_top)
   );

   assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_nxt && oe) |-> (y == '0));
   assert_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!zero_nxt && oe && src_sel == 2'd1) |-> (y == din));
   assert_zero_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_nxt && !cin) |=> (pc_q == '0));

endmodule

// File: tb/useq_slice_tb.sv
module useq_slice_tb;

   localparam int  NS  = 3;
   localparam int  SW  = 4;
   localparam int  AW  = NS * SW;
   localparam time CYC = 20ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] din = '0;
   logic [1:0]    sel = 2'd0;
   logic          ld = 1'b0, fe = 1'b0, pu = 1'b0, zf = 1'b0, ci = 1'b0, oe = 1'b1;
   wire  [AW-1:0] y;
   wire  [NS:0]   carry;

   assign carry[0] = ci;

   always #(CYC/2) clk = ~clk;

   for (genvar s = 0; s < NS; s++) begin : g_sl
      if (s == 0) begin : g_dut
         useq_slice #(.W(SW), .DEPTH(4)) u_dut (
            .clk(clk), .rst_n(rst_n), .din(din[s*SW +: SW]), .src_sel(sel),
            .areg_ld(ld), .stk_en(fe), .stk_push(pu), .zero_nxt(zf),
            .cin(carry[s]), .oe(oe), .y(y[s*SW +: SW]), .cout(carry[s+1]));
      end else begin : g_ext
         useq_slice #(.W(SW), .DEPTH(4)) u_sl (
            .clk(clk), .rst_n(rst_n), .din(din[s*SW +: SW]), .src_sel(sel),
            .areg_ld(ld), .stk_en(fe), .stk_push(pu), .zero_nxt(zf),
            .cin(carry[s]), .oe(oe), .y(y[s*SW +: SW]), .cout(carry[s+1]));
      end
   end

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic [AW-1:0] m_ar, m_pc;
   logic [AW-1:0] m_stk [4];
   logic [1:0]    m_sp;

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [AW-1:0] model_y(input logic [1:0] s, input logic [AW-1:0] d, input logic z);
      logic [AW-1:0] v;
      case (s)
         2'd0: v = m_ar;
         2'd1: v = d;
         2'd2: v = m_pc;
         default: v = m_stk[m_sp];
      endcase
      return z ? '0 : v;
   endfunction

   // one clock cycle: drive, compare at mid-cycle, update the model at the edge
   task automatic cyc(input logic [1:0] s, input logic [AW-1:0] d, input logic l,
                      input logic e, input logic p, input logic z, input logic c,
                      input logic o, input string req);
      logic [AW-1:0] ey;
      @(negedge clk);
      sel = s; din = d; ld = l; fe = e; pu = p; zf = z; ci = c; oe = o;
      #1;
      ey = model_y(s, d, z);
      if (o) check(req, y, ey);
      else   check("R9", y, {AW{1'bz}});
      check({req, " carry"}, {{(AW-1){1'b0}}, carry[NS]}, {{(AW-1){1'b0}}, c & (&ey)});
      @(posedge clk);
      if (l) m_ar = d;
      if (e && p) begin
         m_stk[m_sp + 2'd1] = m_pc;
         m_sp = m_sp + 2'd1;
      end else if (e) begin
         m_sp = m_sp - 2'd1;
      end
      m_pc = ey + AW'(c);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CYC * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [15:0] lfsr;
      m_ar = '0; m_pc = '0; m_sp = '0;
      for (int i = 0; i < 4; i++) m_stk[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: cleared state seen through sources 0, 2, 3
      cyc(2'd0, 12'h5A5, 0, 0, 0, 0, 0, 1, "R1");
      cyc(2'd2, 12'h5A5, 0, 0, 0, 0, 0, 1, "R1");
      cyc(2'd3, 12'h5A5, 0, 0, 0, 0, 0, 1, "R1");

      // R2 R4 R10: jump to every address, then continue once
      for (int a = 0; a < (1 << AW); a++) begin
         cyc(2'd1, AW'(a), 0, 0, 0, 0, 1, 1, "R2");
         cyc(2'd2, AW'(a ^ 12'hFFF), 0, 0, 0, 0, 1, 1, "R10");
      end
      // R4: carry-in 0 holds the address
      cyc(2'd1, 12'h0F3, 0, 0, 0, 0, 0, 1, "R4");
      cyc(2'd2, 12'h000, 0, 0, 0, 0, 0, 1, "R4");
      cyc(2'd2, 12'h000, 0, 0, 0, 0, 1, 1, "R4");
      cyc(2'd2, 12'h000, 0, 0, 0, 0, 1, 1, "R4");

      // R3: load, then hold
      cyc(2'd1, 12'hABC, 1, 0, 0, 0, 1, 1, "R3");
      cyc(2'd0, 12'h123, 0, 0, 0, 0, 1, 1, "R3");
      cyc(2'd0, 12'h321, 1, 0, 0, 0, 1, 1, "R3");
      cyc(2'd0, 12'h777, 0, 0, 0, 0, 1, 1, "R3");

      // R5: forced zero for every source
      for (int s = 0; s < 4; s++) begin
         cyc(2'(s), 12'hFFF, 0, 0, 0, 1, 1, 1, "R5");
         cyc(2'd2, 12'h000, 0, 0, 0, 0, 1, 1, "R5");
      end

      // R6 R7: nested calls four deep, then returns
      cyc(2'd1, 12'h100, 0, 0, 0, 0, 1, 1, "R6");
      for (int k = 0; k < 4; k++) begin
         cyc(2'd2, 12'h000, 0, 0, 0, 0, 1, 1, "R6");
         cyc(2'd1, AW'(12'h200 + 12'h100 * k), 0, 1, 1, 0, 1, 1, "R6");
      end
      for (int k = 0; k < 4; k++) begin
         cyc(2'd3, 12'h000, 0, 1, 0, 0, 1, 1, "R7");
         cyc(2'd2, 12'h000, 0, 0, 0, 0, 1, 1, "R7");
      end
      // R7: disabled stack stays put even with push asserted
      cyc(2'd3, 12'h000, 0, 0, 1, 0, 1, 1, "R7");
      cyc(2'd3, 12'h000, 0, 0, 0, 0, 1, 1, "R7");

      // R8: five pushes wrap over the oldest entry, then pops all around
      for (int k = 0; k < 5; k++) begin
         cyc(2'd1, AW'(12'h400 + 12'h011 * k), 0, 1, 1, 0, 1, 1, "R8");
      end
      for (int k = 0; k < 6; k++) cyc(2'd3, 12'h000, 0, 1, 0, 0, 1, 1, "R8");

      // R9: output released
      cyc(2'd1, 12'hFFF, 0, 0, 0, 0, 1, 0, "R9");
      cyc(2'd2, 12'h000, 0, 0, 0, 0, 1, 1, "R9");

      // R10: mixed pseudo-random control stream
      lfsr = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(lfsr[1:0], {lfsr[11:0] ^ lfsr[15:4]}, lfsr[2], lfsr[3], lfsr[4],
             (lfsr[8:5] == 4'h0), lfsr[9] | lfsr[10], (lfsr[14:12] != 3'd0), "R10");
      end

      summary();
   end

endmodule